// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a running time of day for precision time synchronisation. On every clock edge it adds a programmable fixed-point step to a nanoseconds register. The step has 8 integer bits and 32 fraction bits. When the nanoseconds value reaches a programmable wrap limit, the limit is subtracted and a seconds register counts up.

The time register stores only 8 fraction bits. The lower 24 bits of the step are summed in a separate error accumulator. Each carry out of that accumulator adds one least significant bit to the stored fraction, so the long-term rate matches the full-precision step.

Control uses three single-cycle strobes:
- **Set time:** writes the time directly.
- **Frequency trim:** replaces the nominal step.
- **Phase trim:** adds an extra step on top of the nominal one for a programmed number of cycles.

Top module: `tod_counter`

## Requirements
- R1: A synchronous active-high reset clears the nanoseconds, seconds, nominal step, trim step, trim cycle count and low-fraction accumulator. With no step loaded afterwards, both outputs stay at zero.
- R2: Each clock, the nanoseconds output advances by the effective step. The output uses a 30.8 format: integer nanoseconds in bits 37:8 and fraction in bits 7:0. A step of 8.0 ns (`step_period` = 40'h08_0000_0000) therefore adds 38'h800.
- R3: A `set_period` strobe latches `step_period`, which has integer ns in bits 39:32 and fraction in bits 31:0. The edge that latches it still uses the previous step, and the new step applies from the following edge.
- R4: Step bits 23:0 are summed in a 24-bit accumulator, and each carry out of it adds one extra 2^-8 ns to the nanoseconds output in that cycle. A step of 40'h00_0080_0000 therefore adds exactly 2 LSBs over any 4 cycles.
- R5: When nanoseconds plus the step reaches `wrap_limit` (30.8 format, 38'd256_000_000_000 for one second), the new value is that sum minus `wrap_limit`, so the remainder is kept, and the seconds output increments by one in the same cycle.
- R6: A `set_time` strobe loads `time_ns_in` and `time_sec_in` into the outputs on that edge, and this load takes priority over the increment. The low-fraction accumulator keeps running.
- R7: A `set_trim` strobe latches `trim_period` and `trim_cycles`. For the next `trim_cycles` edges after the latching edge, the step is nominal plus trim, and after that it is nominal only. A count of zero applies no trim.
- R8: A `set_trim` strobe issued while a trim is running restarts the count with the new values. The latching edge itself still uses the old trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_time | input | 1 | Single-cycle strobe that loads the time |
| time_ns_in | input | 38 | Nanoseconds value to load, 30.8 format |
| time_sec_in | input | 48 | Seconds value to load |
| set_period | input | 1 | Single-cycle strobe that latches the nominal step |
| step_period | input | 40 | Nominal step, 8.32 format |
| wrap_limit | input | 38 | Nanoseconds wrap limit, 30.8 format |
| set_trim | input | 1 | Single-cycle strobe that latches a phase trim |
| trim_period | input | 40 | Extra step during the trim, 8.32 format |
| trim_cycles | input | 32 | Number of cycles the trim lasts |
| tod_ns | output | 38 | Nanoseconds of the time of day, 30.8 format |
| tod_sec | output | 48 | Seconds of the time of day |

## Verification
The properties assume that the effective step (nominal plus any trim) is always smaller than `wrap_limit`, so at most one subtraction of the limit happens per cycle. They also assume that any loaded nanoseconds value is already below `wrap_limit`. Under those assumptions, the nanoseconds value falls exactly when the seconds value rises.

The stimulus keeps `wrap_limit` fixed at one second and keeps every step below 11 ns. It only ever loads nanoseconds values under one second, including the values placed just below the wrap point to force a rollover.

// File: rtl/tod_pkg.sv
package tod_pkg;
   // Default geometry of the time-of-day counter
   localparam int TOD_NS_INT_W   = 30;
   localparam int TOD_NS_FRAC_W  = 8;
   localparam int TOD_SEC_W      = 48;
   localparam int TOD_STEP_INT_W = 8;
   localparam int TOD_STEP_FRC_W = 32;
   localparam int TOD_TRIM_CNT_W = 32;
endpackage

// File: rtl/tod_rate.sv
// Holds the nominal step and the phase-trim state; produces the effective step.
module tod_rate #(
   parameter int STEP_W  = 40,
   parameter int CNT_W   = 32,
   parameter int SUM_W   = STEP_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_period,
   input  logic [STEP_W-1:0] step_period,
   input  logic              set_trim,
   input  logic [STEP_W-1:0] trim_period,
   input  logic [CNT_W-1:0]  trim_cycles,
   output logic [SUM_W-1:0]  step_eff
);
   logic [STEP_W-1:0] nom_q;
   logic [STEP_W-1:0] trim_q;
   logic [CNT_W-1:0]  left_q;
   logic              trimming;

   assign trimming = (left_q != '0);
   assign step_eff = {1'b0, nom_q} + (trimming ? {1'b0, trim_q} : '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         nom_q  <= '0;
         trim_q <= '0;
         left_q <= '0;
      end else begin
         if (set_period) nom_q <= step_period;
         if (set_trim) begin
            trim_q <= trim_period;
            left_q <= trim_cycles;
         end else if (trimming) begin
            left_q <= left_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/tod_frac_acc.sv
// Error accumulator for step fraction bits finer than the stored fraction.
module tod_frac_acc #(
   parameter int LOW_W = 24,
   parameter int PORT_W = (LOW_W > 0) ? LOW_W : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PORT_W-1:0] step_low,
   output logic              carry
);
   generate
      if (LOW_W > 0) begin : g_acc
         logic [LOW_W-1:0] acc_q;
         logic [LOW_W:0]   acc_sum;
         assign acc_sum = {1'b0, acc_q} + {1'b0, step_low};
         assign carry   = acc_sum[LOW_W];
         always_ff @(posedge clk) begin
            if (rst) acc_q <= '0;
            else     acc_q <= acc_sum[LOW_W-1:0];
         end
      end else begin : g_none
         assign carry = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/tod_clock.sv
// Nanoseconds and seconds registers with modulo wrap and direct load.
module tod_clock #(
   parameter int NS_W  = 38,
   parameter int SEC_W = 48,
   parameter int HI_W  = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             set_time,
   input  logic [NS_W-1:0]  time_ns_in,
   input  logic [SEC_W-1:0] time_sec_in,
   input  logic [NS_W-1:0]  wrap_limit,
   input  logic [HI_W-1:0]  step_hi,
   input  logic             carry,
   output logic [NS_W-1:0]  tod_ns,
   output logic [SEC_W-1:0] tod_sec
);
   localparam int SUM_W = NS_W + 1;

   logic [SUM_W-1:0] ns_sum;
   logic [NS_W-1:0]  ns_left;
   logic [NS_W-1:0]  ns_next;
   logic             wrap;

   assign ns_sum  = {1'b0, tod_ns} + SUM_W'(step_hi) + SUM_W'(carry);
   assign wrap    = (ns_sum >= {1'b0, wrap_limit});
   assign ns_left = ns_sum[NS_W-1:0] - wrap_limit;
   assign ns_next = wrap ? ns_left : ns_sum[NS_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         tod_ns  <= '0;
         tod_sec <= '0;
      end else if (set_time) begin
         tod_ns  <= time_ns_in;
         tod_sec <= time_sec_in;
      end else begin
         tod_ns <= ns_next;
         if (wrap) tod_sec <= tod_sec + 1'b1;
      end
   end
endmodule

// File: rtl/tod_counter.sv
// Fractional-period time-of-day counter, top level.
module tod_counter #(
   parameter int NS_INT_W   = tod_pkg::TOD_NS_INT_W,
   parameter int NS_FRAC_W  = tod_pkg::TOD_NS_FRAC_W,
   parameter int SEC_W      = tod_pkg::TOD_SEC_W,
   parameter int STEP_INT_W = tod_pkg::TOD_STEP_INT_W,
   parameter int STEP_FRC_W = tod_pkg::TOD_STEP_FRC_W,
   parameter int CNT_W      = tod_pkg::TOD_TRIM_CNT_W,
   parameter int NS_W       = NS_INT_W + NS_FRAC_W,
   parameter int STEP_W     = STEP_INT_W + STEP_FRC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              set_time,
   input  logic [NS_W-1:0]   time_ns_in,
   input  logic [SEC_W-1:0]  time_sec_in,
   input  logic              set_period,
   input  logic [STEP_W-1:0] step_period,
   input  logic [NS_W-1:0]   wrap_limit,
   input  logic              set_trim,
   input  logic [STEP_W-1:0] trim_period,
   input  logic [CNT_W-1:0]  trim_cycles,
   output logic [NS_W-1:0]   tod_ns,
   output logic [SEC_W-1:0]  tod_sec
);
   localparam int SUM_W  = STEP_W + 1;
   localparam int LOW_W  = STEP_FRC_W - NS_FRAC_W;
   localparam int LOW_PW = (LOW_W > 0) ? LOW_W : 1;
   localparam int HI_W   = SUM_W - LOW_W;

   generate
      if (STEP_FRC_W < NS_FRAC_W) begin : g_bad_frac
         $error("step fraction must be at least as wide as the stored fraction");
      end
      if (HI_W > NS_W) begin : g_bad_hi
         $error("step integer part is wider than the nanoseconds register");
      end
   endgenerate

   logic [SUM_W-1:0]  step_eff;
   logic [LOW_PW-1:0] step_low;
   logic [HI_W-1:0]   step_hi;
   logic              frac_carry;

   assign step_hi = step_eff[SUM_W-1:LOW_W];

   generate
      if (LOW_W > 0) begin : g_low
         assign step_low = step_eff[LOW_PW-1:0];
      end else begin : g_nolow
         assign step_low = '0;
      end
   endgenerate

   tod_rate #(
      .STEP_W (STEP_W),
      .CNT_W  (CNT_W),
      .SUM_W  (SUM_W)
   ) u_rate (
      .clk         (clk),
      .rst         (rst),
      .set_period  (set_period),
      .step_period (step_period),
      .set_trim    (set_trim),
      .trim_period (trim_period),
      .trim_cycles (trim_cycles),
      .step_eff    (step_eff)
   );

   tod_frac_acc #(
      .LOW_W  (LOW_W),
      .PORT_W (LOW_PW)
   ) u_frac (
      .clk      (clk),
      .rst      (rst),
      .step_low (step_low),
      .carry    (frac_carry)
   );

   tod_clock #(
      .NS_W  (NS_W),
      .SEC_W (SEC_W),
      .HI_W  (HI_W)
   ) u_clock (
      .clk         (clk),
      .rst         (rst),
      .set_time    (set_time),
      .time_ns_in  (time_ns_in),
      .time_sec_in (time_sec_in),
      .wrap_limit  (wrap_limit),
      .step_hi     (step_hi),
      .carry       (frac_carry),
      .tod_ns      (tod_ns),
      .tod_sec     (tod_sec)
   );
endmodule

// File: rtl/tod_counter_chk.sv
// Property checker bound to tod_counter.
module tod_counter_chk #(
   parameter int NS_W  = 38,
   parameter int SEC_W = 48
) (
   input logic             clk,
   input logic             rst,
   input logic             set_time,
   input logic [NS_W-1:0]  time_ns_in,
   input logic [SEC_W-1:0] time_sec_in,
   input logic [NS_W-1:0]  wrap_limit,
   input logic [NS_W-1:0]  tod_ns,
   input logic [SEC_W-1:0] tod_sec
);
   // R1: the cycle after reset both time outputs read zero
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (tod_ns == '0 && tod_sec == '0));

   // R6: a time load lands exactly on the outputs
   p_load_exact_r6: assert property (@(posedge clk) disable iff (rst)
      set_time |=> (tod_ns == $past(time_ns_in) && tod_sec == $past(time_sec_in)));

   // R5: without a load, seconds rise by zero or one
   p_sec_step_r5: assert property (@(posedge clk) disable iff (rst)
      !set_time |=> (tod_sec == $past(tod_sec) || tod_sec == $past(tod_sec) + 1'b1));

   // R5: seconds rise exactly when nanoseconds fall back
   p_wrap_pair_r5: assert property (@(posedge clk) disable iff (rst)
      !set_time |=> ((tod_sec != $past(tod_sec)) == (tod_ns < $past(tod_ns))));

   // R5: nanoseconds stay below the wrap limit once there
   p_below_limit_r5: assert property (@(posedge clk) disable iff (rst)
      (!set_time && tod_ns < wrap_limit) |=> (tod_ns < $past(wrap_limit)));
endmodule

bind tod_counter tod_counter_chk #(
   .NS_W  (NS_W),
   .SEC_W (SEC_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .set_time    (set_time),
   .time_ns_in  (time_ns_in),
   .time_sec_in (time_sec_in),
   .wrap_limit  (wrap_limit),
   .tod_ns      (tod_ns),
   .tod_sec     (tod_sec)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        set_time = 1'b0;
   logic [37:0] time_ns_in = '0;
   logic [47:0] time_sec_in = '0;
   logic        set_period = 1'b0;
   logic [39:0] step_period = '0;
   logic [37:0] wrap_limit = 38'd256_000_000_000;
   logic        set_trim = 1'b0;
   logic [39:0] trim_period = '0;
   logic [31:0] trim_cycles = '0;
   logic [37:0] tod_ns;
   logic [47:0] tod_sec;

   always #10 clk = ~clk;

   tod_counter dut (
      .clk (clk), .rst (rst),
      .set_time (set_time), .time_ns_in (time_ns_in), .time_sec_in (time_sec_in),
      .set_period (set_period), .step_period (step_period),
      .wrap_limit (wrap_limit),
      .set_trim (set_trim), .trim_period (trim_period), .trim_cycles (trim_cycles),
      .tod_ns (tod_ns), .tod_sec (tod_sec)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string phase = "R1";
   bit    started = 1'b0;
   bit    done = 1'b0;

   // Reference model: whole time in units of 2^-32 ns
   longint m_tot = 0;
   longint m_sec = 0;
   longint m_nom = 0;
   longint m_trim = 0;
   longint m_left = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) begin : model
      longint step;
      longint lim;
      started = 1'b1;
      if (rst) begin
         m_tot = 0; m_sec = 0; m_nom = 0; m_trim = 0; m_left = 0;
      end else begin
         step = m_nom + ((m_left != 0) ? m_trim : 0);
         lim  = longint'(wrap_limit) << 24;
         m_tot = m_tot + step;
         if (m_tot >= lim) begin
            m_tot = m_tot - lim;
            m_sec = m_sec + 1;
         end
         if (set_time) begin
            m_tot = (longint'(time_ns_in) << 24) | (m_tot & 64'hFF_FFFF);
            m_sec = longint'(time_sec_in);
         end
         if (set_period) m_nom = longint'(step_period);
         if (set_trim) begin
            m_trim = longint'(trim_period);
            m_left = longint'(trim_cycles);
         end else if (m_left != 0) begin
            m_left = m_left - 1;
         end
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         check(longint'(tod_ns) == (m_tot >>> 24), phase, longint'(tod_ns), m_tot >>> 24);
         check(longint'(tod_sec) == m_sec, phase, longint'(tod_sec), m_sec);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   task automatic pulse_period(input logic [39:0] v);
      step_period = v; set_period = 1'b1; tick(1); set_period = 1'b0;
   endtask

   task automatic pulse_time(input logic [37:0] ns, input logic [47:0] s);
      time_ns_in = ns; time_sec_in = s; set_time = 1'b1; tick(1); set_time = 1'b0;
   endtask

   task automatic pulse_trim(input logic [39:0] v, input logic [31:0] n);
      trim_period = v; trim_cycles = n; set_trim = 1'b1; tick(1); set_trim = 1'b0;
   endtask

   initial begin
      logic [37:0] base;
      tick(2);
      // R1: reset state
      check(tod_ns == '0, "R1", longint'(tod_ns), 0);
      check(tod_sec == '0, "R1", longint'(tod_sec), 0);
      rst = 1'b0;
      tick(5);
      check(tod_ns == '0, "R1", longint'(tod_ns), 0);

      // R3: the latching edge still uses the old (zero) step
      phase = "R3";
      pulse_period(40'h08_0000_0000);
      check(tod_ns == '0, "R3", longint'(tod_ns), 0);
      tick(1);
      check(tod_ns == 38'h800, "R3", longint'(tod_ns), 38'h800);

      // R2: 8.0 ns per cycle
      phase = "R2";
      tick(20);
      check(tod_ns == (38'd168 << 8), "R2", longint'(tod_ns), 168 << 8);

      // R6: load priority over increment
      phase = "R6";
      pulse_time(38'd999_999_990 << 8, 48'd10);
      check(tod_ns == (38'd999_999_990 << 8), "R6", longint'(tod_ns), 64'd999_999_990 << 8);
      check(tod_sec == 48'd10, "R6", longint'(tod_sec), 10);
      tick(1);
      check(tod_ns == (38'd999_999_998 << 8), "R2", longint'(tod_ns), 64'd999_999_998 << 8);

      // R5: wrap keeps remainder and counts a second
      phase = "R5";
      tick(1);
      check(tod_ns == (38'd6 << 8), "R5", longint'(tod_ns), 6 << 8);
      check(tod_sec == 48'd11, "R5", longint'(tod_sec), 11);

      // R4: fractional step with accumulator carries
      phase = "R4";
      pulse_period(40'h08_1020_0000);
      tick(60);
      pulse_period(40'h00_0080_0000);
      base = tod_ns;
      tick(4);
      check(tod_ns - base == 38'd2, "R4", longint'(tod_ns - base), 2);

      // R5: wrap with fraction bits present
      phase = "R5";
      pulse_period(40'h08_1020_0000);
      pulse_time((38'd999_999_996 << 8) | 38'hC0, 48'd20);
      tick(1);
      check(tod_sec == 48'd21, "R5", longint'(tod_sec), 21);
      check((tod_ns >> 8) == 38'd4, "R5", longint'(tod_ns >> 8), 4);
      tick(10);

      // R7: trim of 2.0 ns for 10 cycles on top of 8.0 ns
      phase = "R7";
      pulse_period(40'h08_0000_0000);
      pulse_time('0, '0);
      pulse_trim(40'h02_0000_0000, 32'd10);
      base = tod_ns;
      tick(10);
      check(tod_ns - base == (38'd100 << 8), "R7", longint'(tod_ns - base), 100 << 8);
      tick(1);
      check(tod_ns - base == (38'd108 << 8), "R7", longint'(tod_ns - base), 108 << 8);

      // R7: zero count applies no trim
      pulse_trim(40'h05_0000_0000, 32'd0);
      base = tod_ns;
      tick(3);
      check(tod_ns - base == (38'd24 << 8), "R7", longint'(tod_ns - base), 24 << 8);

      // R8: reload during a running trim
      phase = "R8";
      pulse_trim(40'h02_0000_0000, 32'd10);
      base = tod_ns;
      tick(3);
      pulse_trim(40'h01_0000_0000, 32'd4);
      tick(5);
      check(tod_ns - base == (38'd84 << 8), "R8", longint'(tod_ns - base), 84 << 8);
      tick(10);

      // R1: reset mid-run clears step as well as time
      phase = "R1";
      rst = 1'b1;
      tick(1);
      check(tod_ns == '0 && tod_sec == '0, "R1", longint'(tod_ns), 0);
      rst = 1'b0;
      tick(3);
      check(tod_ns == '0, "R1", longint'(tod_ns), 0);

      done = 1'b1;
      finish_run();
   end
endmodule